// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps the time of day and the calendar date for a real-time clock. It counts seconds, minutes, hours, day of week, day of month, month and a two-digit year. The values are held internally in binary and are shown as seven visible bytes. Software can choose at run time whether those bytes are BCD or plain binary, and whether hours use 24-hour or 12-hour form. One pulse per second advances the count. The register bus, the alarm comparison and the tick generator all sit outside the block.

A host write to a visible time byte updates that byte. While the freeze control is low, the write also reloads the internal counter from the visible bytes. An accepted tick advances the counter and opens an update window of a fixed number of 32.768 kHz enables. The update-in-progress flag is high during that window. When the window closes, the visible bytes are refreshed and a one-cycle update-done strobe is given. Raising the freeze control stops the refreshes so that software can rewrite the time consistently. Lowering it loads the rewritten time into the counter.

Top module: `rtc_calendar_counter`

## Requirements
- R1: A tick on `sec_tick_i` is accepted only when `osc_ctl_i` equals 3'b010. For any other value the tick changes nothing: the time stays the same, `uip_o` stays low and no strobe follows.
- R2: With `bin_mode_i`=1 each visible byte is the plain binary value. With `bin_mode_i`=0 it is BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R3: With `h24_mode_i`=0 the hours byte carries PM in bit 7 and the hour modulo 12 in bits 6:0, so midnight reads 0x00 and noon reads 0x80 in BCD. A written 12-hour byte with bit 7 set is loaded as that hour plus 12.
- R4: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Day of week runs 1..7, month 1..12 and year 0..99. Each wrap carries into the next field, so Dec 31 23:59:59 of year 99 becomes Jan 1 00:00:00 of year 00, with day of week 7 becoming 1.
- R5: February has 29 days when the full year (`BASE_YEAR` plus the two-digit year, default base 1980) is divisible by 4 and is either not divisible by 100 or divisible by 400. Otherwise it has 28 days.
- R6: While `set_mode_i` is high, the visible bytes are not refreshed by updates or by format changes, `uip_o` stays low, and writes do not reload the counter. The falling edge of `set_mode_i` reloads the counter from the visible bytes.
- R7: An accepted tick with `set_mode_i` low raises `uip_o` on the next cycle. `uip_o` stays high until the `WIN_LEN`-th 32.768 kHz enable after the tick. In the cycle after that enable, the visible bytes hold the new time, `uip_o` is low and `upd_done_o` is high for exactly one cycle.
- R8: A change of `bin_mode_i` or `h24_mode_i` while `set_mode_i` is low re-encodes all visible bytes in the new format on the following cycle.
- R9: Invalid BCD digits are loaded unchanged, for example seconds 0x5A decode to 60. The next tick then rolls that field to 0 and carries into the next field.
- R10: A write (`wr_en_i` with `wr_sel_i` 0..6, where 0=seconds, 1=minutes, 2=hours, 3=day of week, 4=day of month, 5=month, 6=year) shows `wr_data_i` on the selected byte on the next cycle. With `set_mode_i` low it also reloads the counter from all visible bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-second advance pulse |
| slow_en_i | input | 1 | 32.768 kHz enable used to time the update window |
| osc_ctl_i | input | 3 | Oscillator control; counting only at 3'b010 |
| set_mode_i | input | 1 | Freeze control for visible bytes |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| h24_mode_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Byte selected for the write |
| wr_data_i | input | 8 | Write data |
| sec_o | output | 8 | Visible seconds |
| min_o | output | 8 | Visible minutes |
| hour_o | output | 8 | Visible hours |
| wday_o | output | 8 | Visible day of week |
| mday_o | output | 8 | Visible day of month |
| mon_o | output | 8 | Visible month |
| year_o | output | 8 | Visible two-digit year |
| uip_o | output | 1 | Update-in-progress flag |
| upd_done_o | output | 1 | One-cycle update-done strobe |

## Verification
The assertions check, on every cycle, the properties that depend only on cycle relations:
- rejected ticks leave the counter and the flag untouched;
- the frozen visible bytes stay stable;
- a written byte lands on the next cycle;
- `uip_o` rises only after a tick and falls under freeze;
- the strobe lasts a single cycle.

The bench scenarios show the arithmetic content, which no cycle property can express: the carry chain across a year end, the leap and non-leap February ends, BCD versus binary and 12-hour encodings, re-encoding on a format change, the reload when freeze is released, and the rollover from an invalid BCD digit.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned NUM_FIELDS = 7;
  localparam logic [2:0]  OSC_RUN    = 3'b010;

  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HOUR = 2;
  localparam int unsigned F_WDAY = 3;
  localparam int unsigned F_MDAY = 4;
  localparam int unsigned F_MON  = 5;
  localparam int unsigned F_YEAR = 6;

  // member order makes a cast to vis_t index 0 = seconds
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] sec;
  } cal_t;

  typedef logic [NUM_FIELDS-1:0][7:0] vis_t;

  function automatic logic [7:0] bin2bcd(input logic [7:0] v);
    logic [7:0] t, u;
    t = v / 8'd10;
    u = v % 8'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [7:0] bcd2bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction
endpackage

// File: rtl/rtc_cal_encode.sv
module rtc_cal_encode
  import rtc_cal_pkg::*;
(
  input  cal_t t_i,
  input  logic bin_i,
  input  logic h24_i,
  output vis_t v_o
);
  vis_t       raw;
  logic [7:0] h12;
  logic [7:0] h12_enc;
  logic       pm;

  assign raw = vis_t'(t_i);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    if (g == F_HOUR) begin : g_hour
      assign h12     = t_i.hour % 8'd12;
      assign pm      = t_i.hour >= 8'd12;
      assign h12_enc = bin_i ? h12 : bin2bcd(h12);
      assign v_o[g]  = h24_i ? (bin_i ? raw[g] : bin2bcd(raw[g]))
                             : {pm, h12_enc[6:0]};
    end else begin : g_plain
      assign v_o[g] = bin_i ? raw[g] : bin2bcd(raw[g]);
    end
  end
endmodule

// File: rtl/rtc_cal_decode.sv
module rtc_cal_decode
  import rtc_cal_pkg::*;
(
  input  vis_t v_i,
  input  logic bin_i,
  input  logic h24_i,
  output cal_t t_o
);
  vis_t       dec;
  logic [7:0] hmask;
  logic [7:0] hval;

  assign hmask = {1'b0, v_i[F_HOUR][6:0]};
  assign hval  = bin_i ? hmask : bcd2bin(hmask);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    if (g == F_HOUR) begin : g_hour
      assign dec[g] = (!h24_i && v_i[g][7]) ? hval + 8'd12 : hval;
    end else begin : g_plain
      assign dec[g] = bin_i ? v_i[g] : bcd2bin(v_i[g]);
    end
  end

  assign t_o = cal_t'(dec);
endmodule

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
  import rtc_cal_pkg::*;
#(
  parameter int unsigned BASE_YEAR = 1980
) (
  input  cal_t cur_i,
  output cal_t nxt_o
);
  int unsigned full_year;
  logic        leap;
  logic [7:0]  dim;
  logic [7:0]  s1, m1, h1, d1, mo1, y1;

  assign full_year = BASE_YEAR + 32'(cur_i.year);
  assign leap = (full_year % 4 == 0) &&
                ((full_year % 100 != 0) || (full_year % 400 == 0));

  always_comb begin
    case (cur_i.mon)
      8'd2:                        dim = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:     dim = 8'd30;
      default:                     dim = 8'd31;
    endcase
  end

  always_comb begin
    nxt_o = cur_i;
    s1  = cur_i.sec + 8'd1;
    m1  = cur_i.minute + 8'd1;
    h1  = cur_i.hour + 8'd1;
    d1  = cur_i.mday + 8'd1;
    mo1 = cur_i.mon + 8'd1;
    y1  = cur_i.year + 8'd1;
    if (s1 < 8'd60) nxt_o.sec = s1;
    else begin
      nxt_o.sec = 8'd0;
      if (m1 < 8'd60) nxt_o.minute = m1;
      else begin
        nxt_o.minute = 8'd0;
        if (h1 < 8'd24) nxt_o.hour = h1;
        else begin
          nxt_o.hour = 8'd0;
          nxt_o.wday = (cur_i.wday >= 8'd7) ? 8'd1 : cur_i.wday + 8'd1;
          if (d1 == 8'd0) nxt_o.mday = 8'd1;
          else if (d1 > dim) begin
            nxt_o.mday = 8'd1;
            if (mo1 > 8'd12) begin
              nxt_o.mon  = 8'd1;
              nxt_o.year = (y1 >= 8'd100) ? 8'd0 : y1;
            end else nxt_o.mon = mo1;
          end else nxt_o.mday = d1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_cal_window.sv
module rtc_cal_window #(
  parameter int unsigned WIN_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic slow_en_i,
  input  logic set_i,
  output logic uip_o,
  output logic close_o,
  output logic done_o
);
  localparam int unsigned CW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          uip_q;
  logic          done_q;

  assign close_o = active_q && slow_en_i && (cnt_q == LAST) && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      uip_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= close_o;
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        uip_q    <= !set_i;
      end else begin
        if (close_o) active_q <= 1'b0;
        else if (active_q && slow_en_i) cnt_q <= cnt_q + 1'b1;
        if (close_o || set_i) uip_q <= 1'b0;
      end
    end
  end

  assign uip_o  = uip_q;
  assign done_o = done_q;

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_uip_after_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uip_o) |-> $past(start_i));
  assert_uip_low_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !uip_o);
  assert_uip_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !uip_o);
endmodule

// File: rtl/rtc_calendar_counter.sv
module rtc_calendar_counter
  import rtc_cal_pkg::*;
#(
  parameter int unsigned BASE_YEAR = 1980,
  parameter int unsigned WIN_LEN   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sec_tick_i,
  input  logic       slow_en_i,
  input  logic [2:0] osc_ctl_i,
  input  logic       set_mode_i,
  input  logic       bin_mode_i,
  input  logic       h24_mode_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       uip_o,
  output logic       upd_done_o
);
  localparam cal_t CAL_RST = '{year: 8'd0, mon: 8'd1, mday: 8'd1, wday: 8'd1,
                               hour: 8'd0, minute: 8'd0, sec: 8'd0};

  cal_t       cur_q, adv_t, dec_t;
  vis_t       vis_q, vis_w, enc_v, vis_base;
  logic [1:0] fmt_q;
  logic       set_q;
  logic       wr_ok, reload, tick_ok, fmt_chg, close;

  assign wr_ok   = wr_en_i && (32'(wr_sel_i) < NUM_FIELDS);
  assign reload  = !set_mode_i && (wr_ok || set_q);
  assign tick_ok = sec_tick_i && (osc_ctl_i == OSC_RUN) && !reload;
  assign fmt_chg = !set_mode_i && ({bin_mode_i, h24_mode_i} != fmt_q);

  always_comb begin
    vis_w = vis_q;
    if (wr_ok) vis_w[wr_sel_i] = wr_data_i;
  end

  rtc_cal_decode u_dec (.v_i(vis_w), .bin_i(bin_mode_i), .h24_i(h24_mode_i), .t_o(dec_t));
  rtc_cal_encode u_enc (.t_i(cur_q), .bin_i(bin_mode_i), .h24_i(h24_mode_i), .v_o(enc_v));
  rtc_cal_advance #(.BASE_YEAR(BASE_YEAR)) u_adv (.cur_i(cur_q), .nxt_o(adv_t));

  rtc_cal_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk_i, .rst_ni, .start_i(tick_ok), .slow_en_i, .set_i(set_mode_i),
    .uip_o, .close_o(close), .done_o(upd_done_o)
  );

  always_comb begin
    vis_base = ((close && !set_mode_i) || fmt_chg) ? enc_v : vis_q;
    if (wr_ok) vis_base[wr_sel_i] = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= CAL_RST;
      vis_q <= vis_t'(CAL_RST);
      fmt_q <= 2'b01;
      set_q <= 1'b0;
    end else begin
      set_q <= set_mode_i;
      fmt_q <= {bin_mode_i, h24_mode_i};
      vis_q <= vis_base;
      if (reload)       cur_q <= dec_t;
      else if (tick_ok) cur_q <= adv_t;
    end
  end

  assign sec_o  = vis_q[F_SEC];
  assign min_o  = vis_q[F_MIN];
  assign hour_o = vis_q[F_HOUR];
  assign wday_o = vis_q[F_WDAY];
  assign mday_o = vis_q[F_MDAY];
  assign mon_o  = vis_q[F_MON];
  assign year_o = vis_q[F_YEAR];

  assert_osc_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && osc_ctl_i != OSC_RUN && !reload) |=> $stable(cur_q));
  assert_osc_no_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && osc_ctl_i != OSC_RUN && !uip_o) |=> !uip_o);
  assert_freeze_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_mode_i && !wr_en_i) |=> $stable(vis_q));
  assert_write_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> vis_q[$past(wr_sel_i)] == $past(wr_data_i));
endmodule

// File: tb/tb_rtc_calendar_counter.sv
module tb_rtc_calendar_counter;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sec_tick = 1'b0, slow_en = 1'b0;
  logic [2:0] osc_ctl = 3'b010;
  logic       set_mode = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
  logic       uip_o, upd_done_o;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  rtc_calendar_counter dut (
    .clk_i(clk), .rst_ni, .sec_tick_i(sec_tick), .slow_en_i(slow_en),
    .osc_ctl_i(osc_ctl), .set_mode_i(set_mode), .bin_mode_i(bin_mode),
    .h24_mode_i(h24_mode), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sec_o, .min_o, .hour_o, .wday_o, .mday_o, .mon_o, .year_o, .uip_o, .upd_done_o
  );

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div++;
      slow_en = (div % 3 == 0);
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
  endtask

  // tick, then wait for the strobe; checks flag and strobe shape
  task automatic tick(input string req, input logic exp_uip, input logic exp_done);
    logic saw_uip, saw_done;
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    saw_uip = uip_o; saw_done = 1'b0;
    for (int i = 0; i < 120; i++) begin
      if (upd_done_o) begin saw_done = 1'b1; break; end
      if (!exp_uip && uip_o) saw_uip = 1'b1;
      @(negedge clk);
    end
    chk(req, "uip after tick", {7'd0, saw_uip}, {7'd0, exp_uip});
    chk(req, "update strobe seen", {7'd0, saw_done}, {7'd0, exp_done});
    if (saw_done) begin
      chk("R7", "uip low at strobe", {7'd0, uip_o}, 8'd0);
      @(negedge clk);
      chk("R7", "strobe one cycle", {7'd0, upd_done_o}, 8'd0);
    end
  endtask

  task automatic t_reset;
    chk("R7", "reset uip", {7'd0, uip_o}, 8'd0);
    chk("R4", "reset sec", sec_o, 8'h00);
    chk("R4", "reset mday", mday_o, 8'h01);
    chk("R4", "reset mon", mon_o, 8'h01);
  endtask

  task automatic t_year_end;
    set_hms(8'h23, 8'h59, 8'h59);
    wr(3'd3, 8'h07); wr(3'd4, 8'h31); wr(3'd5, 8'h12); wr(3'd6, 8'h99);
    chk("R10", "written year", year_o, 8'h99);
    tick("R7", 1'b1, 1'b1);
    chk("R4", "sec wrap", sec_o, 8'h00);
    chk("R4", "min wrap", min_o, 8'h00);
    chk("R4", "hour wrap", hour_o, 8'h00);
    chk("R4", "wday wrap", wday_o, 8'h01);
    chk("R4", "mday wrap", mday_o, 8'h01);
    chk("R4", "mon wrap", mon_o, 8'h01);
    chk("R4", "year wrap", year_o, 8'h00);
  endtask

  task automatic t_leap;
    wr(3'd6, 8'h20); wr(3'd5, 8'h02); wr(3'd4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h59);
    tick("R5", 1'b1, 1'b1);
    chk("R5", "2000 feb 29", mday_o, 8'h29);
    chk("R5", "2000 still feb", mon_o, 8'h02);
    set_hms(8'h23, 8'h59, 8'h59);
    tick("R5", 1'b1, 1'b1);
    chk("R5", "leap mday to 1", mday_o, 8'h01);
    chk("R5", "leap mon to 3", mon_o, 8'h03);
    wr(3'd6, 8'h21); wr(3'd5, 8'h02); wr(3'd4, 8'h28);
    set_hms(8'h23, 8'h59, 8'h59);
    tick("R5", 1'b1, 1'b1);
    chk("R5", "2001 mday", mday_o, 8'h01);
    chk("R5", "2001 mon", mon_o, 8'h03);
  endtask

  task automatic t_binary;
    set_hms(8'h12, 8'h34, 8'h56);
    @(negedge clk); bin_mode = 1'b1;
    @(negedge clk);
    chk("R8", "bin sec", sec_o, 8'h38);
    chk("R2", "bin min", min_o, 8'h22);
    chk("R2", "bin hour", hour_o, 8'h0C);
    bin_mode = 1'b0;
    @(negedge clk);
    chk("R2", "bcd sec", sec_o, 8'h56);
  endtask

  task automatic t_12h;
    h24_mode = 1'b0;
    @(negedge clk);
    chk("R3", "noon 12h", hour_o, 8'h80);
    wr(3'd2, 8'h91);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tick("R3", 1'b1, 1'b1);
    chk("R3", "midnight 12h", hour_o, 8'h00);
    wr(3'd2, 8'h81);
    h24_mode = 1'b1;
    @(negedge clk);
    chk("R3", "pm 1 to 24h", hour_o, 8'h13);
  endtask

  task automatic t_osc;
    wr(3'd1, 8'h00); wr(3'd0, 8'h05);
    osc_ctl = 3'b000;
    tick("R1", 1'b0, 1'b0);
    chk("R1", "sec held osc 000", sec_o, 8'h05);
    osc_ctl = 3'b011;
    tick("R1", 1'b0, 1'b0);
    chk("R1", "sec held osc 011", sec_o, 8'h05);
    osc_ctl = 3'b010;
    tick("R1", 1'b1, 1'b1);
    chk("R1", "sec runs osc 010", sec_o, 8'h06);
  endtask

  task automatic t_freeze;
    @(negedge clk); set_mode = 1'b1;
    tick("R6", 1'b0, 1'b1);
    chk("R6", "frozen sec", sec_o, 8'h06);
    wr(3'd0, 8'h30);
    chk("R10", "write in freeze", sec_o, 8'h30);
    @(negedge clk); bin_mode = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6", "no reencode in freeze", sec_o, 8'h30);
    bin_mode = 1'b0;
    @(negedge clk); set_mode = 1'b0;
    @(negedge clk);
    tick("R6", 1'b1, 1'b1);
    chk("R6", "reload on release", sec_o, 8'h31);
  endtask

  task automatic t_bad_bcd;
    wr(3'd1, 8'h10); wr(3'd0, 8'h5A);
    chk("R9", "raw invalid sec", sec_o, 8'h5A);
    tick("R9", 1'b1, 1'b1);
    chk("R9", "invalid sec rolls", sec_o, 8'h00);
    chk("R9", "carry to min", min_o, 8'h11);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_year_end();
    t_leap();
    t_binary();
    t_12h();
    t_osc();
    t_freeze();
    t_bad_bcd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule